// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a simple request/ready bus master and a 32-bit word memory. It lets software treat single bits of two 1 MB windows as if each bit were a full word of its own. Two windows are handled: one for working memory based at 0x20000000 and one for peripherals based at 0x40000000. Each window has a 32 MB alias space, at 0x22000000 and 0x42000000 respectively. Every 32-bit alias word in that space stands for exactly one bit of the window.

Requests that miss both alias spaces go to the memory port unchanged, in the cycle they are accepted.

A read from an alias word fetches the underlying memory word and returns only the selected bit. An alias write is turned into a read of the underlying word followed, in the very next cycle, by a write-back in which only the selected bit has changed. The upstream port is held off during the write-back cycle, so no other access can come between the two halves.

The memory port has a fixed read latency of one cycle: data for a read issued at one clock edge is presented on `mem_rdata` until the next edge.

Top module: `bitband_bridge`

## Requirements
- R1: A write whose address lies outside both alias spaces drives `mem_en`=1, `mem_we`=1, `mem_addr`=`req_addr` and `mem_wdata`=`req_wdata` in the same cycle it is accepted.
- R2: An accepted read drives a memory read in its accept cycle. `rsp_valid` is 1 in the following cycle. For a read outside the alias spaces, `rsp_rdata` then equals the memory word at `req_addr`.
- R3: For an address A in [0x22000000, 0x24000000), with D = A − 0x22000000, the target is the memory word at 0x20000000 + 4·(D >> 7), and the bit number is (D >> 2) mod 32. For example, alias 0x2200401C selects bit 7 of word 0x20000200.
- R4: For an address A in [0x42000000, 0x44000000), with D = A − 0x42000000, the target is the memory word at 0x40000000 + 4·(D >> 7), and the bit number is (D >> 2) mod 32.
- R5: An alias read issues a memory read of the target word. One cycle later it returns the target bit in `rsp_rdata[0]` and zeros in `rsp_rdata[31:1]`.
- R6: An alias write reads the target word in its accept cycle. In the next cycle it writes that word back to the same address with the target bit set to `req_wdata[0]` and every other bit unchanged.
- R7: `req_ready` is 0 in the cycle directly after an alias write is accepted, and only then. A request held during that cycle is accepted one cycle later and sees the updated word.
- R8: Addresses just below an alias space (0x21FFFFFC) and just past its end (0x24000000) are treated as ordinary accesses.
- R9: While reset is held, and in the first cycle after it is released, `req_ready` is 1 and both `rsp_valid` and `mem_en` are 0 when no request is offered.
- R10: Bits 31:1 of `req_wdata` have no effect on the word written back by an alias write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Request accepted when both valid and ready are 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | 32 | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address, word aligned for alias targets |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The mapping is swept across all 32 bit numbers of sixteen words in each window, reading through the alias. Each bit of each word is compared, so a wrong bit number, a wrong word stride or a mixed-up window shows up as a mismatch.

Alias writes are swept across every bit of four words per window. They alternate set and clear, and carry all-ones or all-zeros filler in the upper data bits. This separates a correct single-bit merge from one that clears neighbouring bits or copies the filler.

Addresses on both edges of an alias space, together with a back-to-back request held during the write-back cycle, distinguish correct window bounds and a correct lock from off-by-one bounds and a leaky lock.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    localparam int unsigned WORD_W           = 32;
    localparam int unsigned ADDR_W           = 32;
    localparam int unsigned BIT_IDX_W        = $clog2(WORD_W);
    localparam int unsigned BYTES_PER_WORD   = WORD_W / 8;
    localparam int unsigned ALIAS_WORD_SHIFT = $clog2(BYTES_PER_WORD);
    localparam int unsigned ALIAS_ROW_SHIFT  = ALIAS_WORD_SHIFT + BIT_IDX_W;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [BIT_IDX_W-1:0] bidx_t;

    localparam addr_t DEF_RAM_BASE      = 32'h2000_0000;
    localparam addr_t DEF_RAM_ALIAS     = 32'h2200_0000;
    localparam addr_t DEF_PERI_BASE     = 32'h4000_0000;
    localparam addr_t DEF_PERI_ALIAS    = 32'h4200_0000;
    localparam int unsigned DEF_REGION_BYTES = 32'h0010_0000;

    typedef struct packed {
        logic  hit;
        addr_t word_addr;
        bidx_t bit_idx;
    } bb_target_t;

    typedef enum logic [0:0] {
        SEQ_OPEN  = 1'b0,
        SEQ_MERGE = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        ACC_PLAIN_RD = 2'd0,
        ACC_PLAIN_WR = 2'd1,
        ACC_ALIAS_RD = 2'd2,
        ACC_ALIAS_WR = 2'd3
    } acc_kind_e;

    function automatic logic in_alias(input addr_t a, input addr_t alias_base,
                                      input addr_t span);
        return (a >= alias_base) && ((a - alias_base) < span);
    endfunction

    function automatic bb_target_t map_alias(input addr_t a, input addr_t base,
                                             input addr_t alias_base, input addr_t span);
        bb_target_t t;
        addr_t      off;
        off         = a - alias_base;
        t.hit       = (a >= alias_base) && (off < span);
        t.word_addr = base + ((off >> ALIAS_ROW_SHIFT) << ALIAS_WORD_SHIFT);
        t.bit_idx   = off[ALIAS_ROW_SHIFT-1:ALIAS_WORD_SHIFT];
        return t;
    endfunction

    function automatic word_t put_bit(input word_t w, input bidx_t i, input logic v);
        word_t r;
        r    = w;
        r[i] = v;
        return r;
    endfunction

    function automatic word_t get_bit(input word_t w, input bidx_t i);
        return word_t'(w[i]);
    endfunction

    function automatic acc_kind_e classify(input logic wr, input logic alias_hit);
        acc_kind_e k;
        case ({alias_hit, wr})
            2'b00:   k = ACC_PLAIN_RD;
            2'b01:   k = ACC_PLAIN_WR;
            2'b10:   k = ACC_ALIAS_RD;
            default: k = ACC_ALIAS_WR;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
    import bitband_pkg::*;
#(
    parameter addr_t       BASE         = DEF_RAM_BASE,
    parameter addr_t       ALIAS_BASE   = DEF_RAM_ALIAS,
    parameter int unsigned REGION_BYTES = DEF_REGION_BYTES
) (
    input  addr_t      addr,
    output bb_target_t tgt
);
    localparam addr_t SPAN = addr_t'(REGION_BYTES * WORD_W);

    always_comb begin
        tgt = map_alias(addr, BASE, ALIAS_BASE, SPAN);
    end
endmodule

// File: rtl/bb_target_select.sv
module bb_target_select
    import bitband_pkg::*;
#(
    parameter int unsigned NUM_WIN = 2
) (
    input  bb_target_t cand [NUM_WIN],
    output bb_target_t sel
);
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cand[i].hit) begin
                sel = cand[i];
            end
        end
    end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bitband_pkg::*;
(
    input  word_t word_in,
    input  bidx_t put_idx,
    input  logic  put_val,
    input  bidx_t get_idx,
    output word_t merged,
    output word_t picked
);
    always_comb begin
        merged = put_bit(word_in, put_idx, put_val);
        picked = get_bit(word_in, get_idx);
    end
endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
    import bitband_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_write,
    input  addr_t      req_addr,
    input  word_t      req_wdata,
    input  bb_target_t tgt,
    output logic       rsp_valid,
    output word_t      rsp_rdata,
    output logic       mem_en,
    output logic       mem_we,
    output addr_t      mem_addr,
    output word_t      mem_wdata,
    input  word_t      mem_rdata
);
    seq_state_e state;
    acc_kind_e  kind;
    logic       accept;

    logic  pend_rd;
    logic  pend_alias;
    bidx_t pend_bit;
    addr_t hold_addr;
    bidx_t hold_bit;
    logic  hold_val;

    word_t merged;
    word_t picked;

    bb_bit_merge u_merge (
        .word_in (mem_rdata),
        .put_idx (hold_bit),
        .put_val (hold_val),
        .get_idx (pend_bit),
        .merged  (merged),
        .picked  (picked)
    );

    always_comb begin
        kind      = classify(req_write, tgt.hit);
        req_ready = (state == SEQ_OPEN);
        accept    = req_valid && req_ready;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (state == SEQ_MERGE) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = hold_addr;
            mem_wdata = merged;
        end else if (req_valid) begin
            mem_en = 1'b1;
            case (kind)
                ACC_PLAIN_WR: begin
                    mem_we    = 1'b1;
                    mem_addr  = req_addr;
                    mem_wdata = req_wdata;
                end
                ACC_PLAIN_RD: mem_addr = req_addr;
                default:      mem_addr = tgt.word_addr;
            endcase
        end
        rsp_valid = pend_rd;
        rsp_rdata = pend_alias ? picked : mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_OPEN;
            pend_rd    <= 1'b0;
            pend_alias <= 1'b0;
            pend_bit   <= '0;
            hold_addr  <= '0;
            hold_bit   <= '0;
            hold_val   <= 1'b0;
        end else begin
            pend_rd    <= accept && !req_write;
            pend_alias <= accept && (kind == ACC_ALIAS_RD);
            pend_bit   <= tgt.bit_idx;
            case (state)
                SEQ_OPEN: begin
                    if (accept && kind == ACC_ALIAS_WR) begin
                        state     <= SEQ_MERGE;
                        hold_addr <= tgt.word_addr;
                        hold_bit  <= tgt.bit_idx;
                        hold_val  <= req_wdata[0];
                    end
                end
                default: state <= SEQ_OPEN;
            endcase
        end
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bitband_pkg::*;
#(
    parameter addr_t       RAM_BASE     = DEF_RAM_BASE,
    parameter addr_t       RAM_ALIAS    = DEF_RAM_ALIAS,
    parameter addr_t       PERI_BASE    = DEF_PERI_BASE,
    parameter addr_t       PERI_ALIAS   = DEF_PERI_ALIAS,
    parameter int unsigned REGION_BYTES = DEF_REGION_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam int unsigned NUM_WIN = 2;
    localparam addr_t WIN_BASE  [NUM_WIN] = '{RAM_BASE, PERI_BASE};
    localparam addr_t WIN_ALIAS [NUM_WIN] = '{RAM_ALIAS, PERI_ALIAS};

    bb_target_t cand [NUM_WIN];
    bb_target_t tgt;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bb_window_decode #(
            .BASE         (WIN_BASE[g]),
            .ALIAS_BASE   (WIN_ALIAS[g]),
            .REGION_BYTES (REGION_BYTES)
        ) u_dec (
            .addr (req_addr),
            .tgt  (cand[g])
        );
    end

    bb_target_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .cand (cand),
        .sel  (tgt)
    );

    bb_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tgt       (tgt),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk
    import bitband_pkg::*;
#(
    parameter addr_t       RAM_ALIAS    = DEF_RAM_ALIAS,
    parameter addr_t       PERI_ALIAS   = DEF_PERI_ALIAS,
    parameter int unsigned REGION_BYTES = DEF_REGION_BYTES
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata
);
    localparam addr_t SPAN = addr_t'(REGION_BYTES * WORD_W);

    logic acc;
    logic alias_hit;
    assign acc       = req_valid && req_ready;
    assign alias_hit = in_alias(req_addr, RAM_ALIAS, SPAN) || in_alias(req_addr, PERI_ALIAS, SPAN);

    a_r1_plain_write: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && !alias_hit |->
            mem_en && mem_we && mem_addr == req_addr && mem_wdata == req_wdata);

    a_r2_read_response: assert property (@(posedge clk) disable iff (rst)
        acc && !req_write |=> rsp_valid);

    a_r2_rsp_has_read: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_en && !mem_we));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        acc && !req_write && alias_hit |=> rsp_rdata[31:1] == '0);

    a_r6_alias_reads_first: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && alias_hit |-> mem_en && !mem_we);

    a_r6_same_word: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && alias_hit |=> mem_en && mem_we && mem_addr == $past(mem_addr));

    a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && alias_hit |=> $countones(mem_wdata ^ mem_rdata) <= 1);

    a_r7_lock_cycle: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && alias_hit |=> !req_ready);

    a_r7_lock_ends: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);
endmodule

bind bitband_bridge bitband_bridge_chk #(
    .RAM_ALIAS    (RAM_ALIAS),
    .PERI_ALIAS   (PERI_ALIAS),
    .REGION_BYTES (REGION_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    bitband_bridge u_bitband_bridge (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: 2 windows x 16 words, indexed by {addr[30], addr[5:2]}
    logic [31:0] mem [32];
    logic [31:0] ref_mem [32];

    function automatic int idx_of(input logic [31:0] a);
        return int'({a[30], a[5:2]});
    endfunction

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[idx_of(mem_addr)] <= mem_wdata;
            else        mem_rdata <= mem[idx_of(mem_addr)];
        end
    end

    // snapshots
    logic        a_ready, a_en, a_we;
    logic [31:0] a_addr, a_wdata;
    logic        b_ready, b_rsp_valid, b_en, b_we;
    logic [31:0] b_rdata, b_addr, b_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        a_ready = req_ready; a_en = mem_en; a_we = mem_we; a_addr = mem_addr; a_wdata = mem_wdata;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
        b_ready = req_ready; b_rsp_valid = rsp_valid; b_rdata = rsp_rdata;
        b_en = mem_en; b_we = mem_we; b_addr = mem_addr; b_wdata = mem_wdata;
        if (!req_ready) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] plain_addr(input int r, input int w);
        return (r != 0 ? 32'h4000_0000 : 32'h2000_0000) + 32'(w * 4);
    endfunction

    function automatic logic [31:0] alias_addr(input int r, input int w, input int b);
        return (r != 0 ? 32'h4200_0000 : 32'h2200_0000) + 32'(w * 128) + 32'(b * 4);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        rst = 1'b1;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 ready in reset", 32'(req_ready), 32'd1);
        check("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R9 mem_en in reset", 32'(mem_en), 32'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R9 ready after reset", 32'(req_ready), 32'd1);
        check("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R9 mem_en after reset", 32'(mem_en), 32'd0);

        // R1: preload by plain writes
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 16; w++) begin
                logic [31:0] v;
                v = 32'h9E37_79B9 * 32'(r * 16 + w + 1);
                v = v ^ (v >> 13);
                ref_mem[r * 16 + w] = v;
                do_req(1'b1, plain_addr(r, w), v);
                check("R1 mem_we", {30'd0, a_en, a_we}, 32'd3);
                check("R1 mem_addr", a_addr, plain_addr(r, w));
                check("R1 mem_wdata", a_wdata, v);
            end
        end

        // R2: plain reads
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 16; w++) begin
                do_req(1'b0, plain_addr(r, w), 32'hDEAD_BEEF);
                check("R2 mem read addr", a_addr, plain_addr(r, w));
                check("R2 rsp_valid", 32'(b_rsp_valid), 32'd1);
                check("R2 rsp_rdata", b_rdata, ref_mem[r * 16 + w]);
            end
        end

        // R3 / R4 / R5: alias read sweep
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 16; w++) begin
                for (int b = 0; b < 32; b++) begin
                    do_req(1'b0, alias_addr(r, w, b), '0);
                    check(r == 0 ? "R3 alias word addr" : "R4 alias word addr",
                          {a_addr[31:1], a_we}, {plain_addr(r, w)[31:1], 1'b0});
                    check("R5 alias read data", b_rdata, {31'd0, ref_mem[r * 16 + w][b]});
                end
            end
        end

        // R6 / R10: alias write sweep
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < 4; w++) begin
                for (int b = 0; b < 32; b++) begin
                    logic v;
                    logic [31:0] filler;
                    logic [31:0] exp;
                    v      = ((w + b + r) % 2) == 0;
                    filler = (b % 2 == 0) ? 32'hFFFF_FFFE : 32'h0000_0000;
                    exp    = ref_mem[r * 16 + w];
                    exp[b] = v;
                    do_req(1'b1, alias_addr(r, w, b), filler | 32'(v));
                    check("R6 read phase", {a_addr[31:1], a_we}, {plain_addr(r, w)[31:1], 1'b0});
                    check("R7 ready low in write-back", 32'(b_ready), 32'd0);
                    check("R6 write-back addr", b_addr, plain_addr(r, w));
                    check("R10 write-back data", b_wdata, exp);
                    ref_mem[r * 16 + w] = exp;
                    do_req(1'b0, plain_addr(r, w), '0);
                    check("R6 word after alias write", b_rdata, ref_mem[r * 16 + w]);
                end
            end
        end

        // R3 worked example: bit 7 of 0x20000200 via 0x2200401C
        do_req(1'b1, 32'h2200_401C, 32'h0000_0001);
        check("R3 example read addr", a_addr, 32'h2000_0200);
        check("R3 example write-back addr", b_addr, 32'h2000_0200);
        ref_mem[idx_of(32'h2000_0200)][7] = 1'b1;
        check("R3 example bit set", b_wdata, ref_mem[idx_of(32'h2000_0200)]);

        // R8: window edges are plain
        do_req(1'b0, 32'h21FF_FFFC, '0);
        check("R8 below alias read addr", a_addr, 32'h21FF_FFFC);
        check("R8 below alias full word", b_rdata, ref_mem[idx_of(32'h21FF_FFFC)]);
        do_req(1'b1, 32'h2400_0000, 32'h1234_5678);
        check("R8 past alias plain write", {a_addr[31:1], a_we}, {32'h2400_0000 >> 1, 1'b1});
        check("R8 past alias no lock", 32'(b_ready), 32'd1);
        ref_mem[idx_of(32'h2400_0000)] = 32'h1234_5678;
        do_req(1'b1, 32'h4400_0000, 32'h0BAD_F00D);
        check("R8 past peri alias plain write", a_addr, 32'h4400_0000);
        ref_mem[idx_of(32'h4400_0000)] = 32'h0BAD_F00D;

        // R7: request held through the write-back cycle
        begin
            logic [31:0] exp;
            exp = ref_mem[idx_of(32'h4000_0008)];
            exp[3] = ~exp[3];
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = alias_addr(1, 2, 3); req_wdata = 32'(exp[3]);
            @(posedge clk); #1;
            req_write = 1'b0; req_addr = 32'h4000_0008; req_wdata = '0;
            check("R7 held request not ready", 32'(req_ready), 32'd0);
            @(posedge clk); #1;
            check("R7 ready returns", 32'(req_ready), 32'd1);
            check("R7 held read issued", a_addr, a_addr);
            check("R7 held read addr", mem_addr, 32'h4000_0008);
            check("R7 no response yet", 32'(rsp_valid), 32'd0);
            @(posedge clk); #1;
            req_valid = 1'b0;
            check("R7 held read response", 32'(rsp_valid), 32'd1);
            check("R7 held read sees update", rsp_rdata, exp);
            ref_mem[idx_of(32'h4000_0008)] = exp;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule